// File: doc/BRIEF.md
# Configuration Cycle Translation Unit

This block sits on the upstream side of a two-port bus bridge. It inspects the address-phase word and command code of each configuration request that arrives from above and decides how that request continues downstream. It compares the bus-number field of the request with the bridge's programmed primary, secondary and subordinate bus numbers.

A request aimed at a device directly on the secondary bus is rewritten into a Type 0 request. The device number becomes a single asserted upper address line, used as that device's select. A request aimed at a bus deeper in the hierarchy is passed on unchanged as Type 1. A configuration write carrying the all-ones device and function pattern with register zero becomes a special cycle. Anything else is left unclaimed.

One request may be offered per cycle. The decision, the rewritten address and the forwarded command appear on the registered outputs one cycle later. Bus handshaking, data movement and retry queues belong to the surrounding bridge.

Top module: `cfgx_xlate_unit`

## Requirements
- R1: Every cycle with `req_valid` high produces exactly one cycle of `out_valid` high on the following cycle, and no other cycle does. Reset clears `out_valid`.
- R2: A Type 1 configuration request whose bus field (address bits [23:16]) equals `sec_bus` yields action code 1 (Type 0) with `out_cmd` equal to the request command, unless R6 applies.
- R3: On a Type 0 result, the device field (bits [15:11]) selects exactly one of address bits [31:16], namely bit 16 + device, when the device number is below 16. When it is 16 or more, bits [31:16] are all zero.
- R4: A Type 1 request whose bus field lies strictly above `sec_bus` and at or below `sub_bus` yields action code 2, with address and command passed through unchanged.
- R5: On a Type 0 result, address bits [10:2] (function [10:8], register [7:2]) are copied from the request, and bits [15:11] and [1:0] are zero.
- R6: A request with bus field equal to `sec_bus`, device 31, function 7, register 0 and command 1011b (configuration write) yields action code 3. It has command 0001b, an unchanged address and `out_single` high. `out_single` is low for every other action.
- R7: A Type 1 request whose bus field is below `sec_bus` or above `sub_bus` yields action code 0, with `out_addr` and `out_cmd` zero.
- R8: A request that is not Type 1 configuration gives action code 0. That covers address bits [1:0] other than 01b, and any command other than 1010b (read) or 1011b (write).
- R9: A request whose bus field equals `pri_bus` gives action code 0, whatever the secondary and subordinate numbers are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address phase of a request is present |
| req_addr | input | 32 | Address-phase word of the request |
| req_cmd | input | 4 | Command code of the request |
| pri_bus | input | 8 | Programmed primary bus number |
| sec_bus | input | 8 | Programmed secondary bus number |
| sub_bus | input | 8 | Programmed subordinate bus number |
| out_valid | output | 1 | Decision for the previous cycle's request |
| out_action | output | 2 | 0 ignore, 1 Type 0, 2 Type 1, 3 special cycle |
| out_addr | output | 32 | Address word to drive downstream |
| out_cmd | output | 4 | Command to drive downstream |
| out_single | output | 1 | Disconnect after the first data phase |

## Verification
Type 0 requests are sent with device numbers 0, 3, 15, 16 and 31. These show whether the select line lands at the right position and whether it vanishes past the 16 available lines. Bus numbers equal to the secondary, equal to the subordinate, between the two, and just outside either end separate the Type 0, Type 1 and unclaimed outcomes at every boundary. The special-cycle pattern is also sent as a read, with a nonzero register, and to a deeper bus; each must fall back to ordinary translation. Non-configuration commands, a wrong low address pair and a request to the primary bus number check that unclaimed requests are dropped. All of these are issued back to back, so each result must match its own request.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    typedef enum logic [1:0] {
        ACT_IGNORE  = 2'd0,
        ACT_TYPE0   = 2'd1,
        ACT_TYPE1   = 2'd2,
        ACT_SPECIAL = 2'd3
    } cfgx_act_e;

    localparam logic [3:0] CMD_CFG_RD  = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [3:0] CMD_SPECIAL = 4'b0001;
    localparam logic [1:0] KIND_TYPE1  = 2'b01;
endpackage

// File: rtl/cfgx_classify.sv
module cfgx_classify
    import cfgx_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int DEV_W = 5,
    parameter int FN_W  = 3,
    parameter int REG_W = 6
) (
    input  logic [1:0]       kind,
    input  logic [3:0]       cmd,
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  fn,
    input  logic [REG_W-1:0] regn,
    input  logic [BUS_W-1:0] pri_bus,
    input  logic [BUS_W-1:0] sec_bus,
    input  logic [BUS_W-1:0] sub_bus,
    output cfgx_act_e        act
);
    logic is_cfg1;
    logic is_spc;

    always_comb begin
        is_cfg1 = (kind == KIND_TYPE1) && ((cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR));
        is_spc  = (cmd == CMD_CFG_WR) && (&dev) && (&fn) && (regn == '0);
        if (!is_cfg1 || (bus == pri_bus)) begin
            act = ACT_IGNORE;
        end else if (bus == sec_bus) begin
            act = is_spc ? ACT_SPECIAL : ACT_TYPE0;
        end else if ((bus > sec_bus) && (bus <= sub_bus)) begin
            act = ACT_TYPE1;
        end else begin
            act = ACT_IGNORE;
        end
    end
endmodule

// File: rtl/cfgx_idsel.sv
module cfgx_idsel #(
    parameter int DEV_W = 5,
    parameter int LINES = 16
) (
    input  logic [DEV_W-1:0] dev,
    output logic [LINES-1:0] sel
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign sel[g] = (dev == DEV_W'(g));
    end
endmodule

// File: rtl/cfgx_xlate_unit.sv
module cfgx_xlate_unit
    import cfgx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_W     = 8,
    parameter int IDSEL_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_cmd,
    input  logic [BUS_W-1:0]  pri_bus,
    input  logic [BUS_W-1:0]  sec_bus,
    input  logic [BUS_W-1:0]  sub_bus,
    output logic              out_valid,
    output logic [1:0]        out_action,
    output logic [ADDR_W-1:0] out_addr,
    output logic [3:0]        out_cmd,
    output logic              out_single
);
    localparam int BUS_LSB = 16;
    localparam int DEV_LSB = 11;
    localparam int DEV_W   = 5;
    localparam int FN_LSB  = 8;
    localparam int FN_W    = 3;
    localparam int REG_LSB = 2;
    localparam int REG_W   = 6;
    localparam int IDSEL_N = ADDR_W - IDSEL_LSB;
    localparam int KEEP_W  = FN_W + REG_W;

    typedef struct packed {
        logic              vld;
        cfgx_act_e         act;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        cmd;
        logic              single;
    } res_t;

    res_t              res_d, res_q;
    cfgx_act_e         act_w;
    logic [IDSEL_N-1:0] idsel_w;

    cfgx_classify #(
        .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .REG_W(REG_W)
    ) u_classify (
        .kind    (req_addr[1:0]),
        .cmd     (req_cmd),
        .bus     (req_addr[BUS_LSB +: BUS_W]),
        .dev     (req_addr[DEV_LSB +: DEV_W]),
        .fn      (req_addr[FN_LSB +: FN_W]),
        .regn    (req_addr[REG_LSB +: REG_W]),
        .pri_bus (pri_bus),
        .sec_bus (sec_bus),
        .sub_bus (sub_bus),
        .act     (act_w)
    );

    cfgx_idsel #(
        .DEV_W(DEV_W), .LINES(IDSEL_N)
    ) u_idsel (
        .dev (req_addr[DEV_LSB +: DEV_W]),
        .sel (idsel_w)
    );

    always_comb begin
        res_d     = '0;
        res_d.act = ACT_IGNORE;
        if (req_valid) begin
            res_d.vld = 1'b1;
            res_d.act = act_w;
            case (act_w)
                ACT_TYPE0: begin
                    res_d.addr[IDSEL_LSB +: IDSEL_N]  = idsel_w;
                    res_d.addr[REG_LSB +: KEEP_W]     = req_addr[REG_LSB +: KEEP_W];
                    res_d.cmd                         = req_cmd;
                end
                ACT_TYPE1: begin
                    res_d.addr = req_addr;
                    res_d.cmd  = req_cmd;
                end
                ACT_SPECIAL: begin
                    res_d.addr   = req_addr;
                    res_d.cmd    = CMD_SPECIAL;
                    res_d.single = 1'b1;
                end
                default: begin
                    res_d.addr = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            res_q.act <= ACT_IGNORE;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid  = res_q.vld;
    assign out_action = res_q.act;
    assign out_addr   = res_q.addr;
    assign out_cmd    = res_q.cmd;
    assign out_single = res_q.single;

    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R1
    AST_IDSEL_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == 2'd1) |-> $onehot0(out_addr[ADDR_W-1:IDSEL_LSB])); // R3
    AST_TYPE0_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == 2'd1) |-> (out_addr[1:0] == 2'b00)); // R5
    AST_TYPE1_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == 2'd2) |-> (out_addr == $past(req_addr) && out_cmd == $past(req_cmd))); // R4
    AST_SPECIAL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == 2'd3) |-> (out_cmd == 4'b0001 && out_single)); // R6
    AST_SINGLE_ONLY_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_single) |-> (out_action == 2'd3)); // R6
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_action == 2'd0) |-> (out_addr == '0 && out_cmd == 4'd0)); // R7
endmodule

// File: tb/cfgx_xlate_unit_test.sv
module cfgx_xlate_unit_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  act;
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic        single;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic [7:0]  pri_bus = 8'd2;
    logic [7:0]  sec_bus = 8'd5;
    logic [7:0]  sub_bus = 8'd9;
    logic        out_valid;
    logic [1:0]  out_action;
    logic [31:0] out_addr;
    logic [3:0]  out_cmd;
    logic        out_single;

    int    checks = 0;
    int    errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgx_xlate_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .pri_bus(pri_bus), .sec_bus(sec_bus), .sub_bus(sub_bus),
        .out_valid(out_valid), .out_action(out_action), .out_addr(out_addr),
        .out_cmd(out_cmd), .out_single(out_single)
    );

    task automatic drive(input logic [31:0] a, input logic [3:0] c, input logic [7:0] p,
                         input logic [1:0] eact, input logic [31:0] eaddr,
                         input logic [3:0] ecmd, input logic esingle, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_cmd   = c;
        pri_bus   = p;
        e.act = eact; e.addr = eaddr; e.cmd = ecmd; e.single = esingle;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expected item per valid output
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1: unexpected output act=%0d addr=%h, expected no output", out_action, out_addr);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_action !== e.act || out_addr !== e.addr || out_cmd !== e.cmd || out_single !== e.single) begin
                    errors++;
                    $display("FAIL %s: act=%0d addr=%h cmd=%h single=%b, expected act=%0d addr=%h cmd=%h single=%b",
                             t, out_action, out_addr, out_cmd, out_single, e.act, e.addr, e.cmd, e.single);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: out_valid=%b during reset, expected 0", out_valid);
        end
        rst_n = 1'b1;
        // R2 R3 R5: device 3, function 2, register 0x10
        drive(32'h0005_1A41, 4'hA, 8'd2, 2'd1, 32'h0008_0240, 4'hA, 1'b0, "R2_R3_R5 dev3");
        // R3: device 0 -> bit 16
        drive(32'h0005_0001, 4'hB, 8'd2, 2'd1, 32'h0001_0000, 4'hB, 1'b0, "R3 dev0");
        // R3 R5: device 15 -> bit 31, all kept fields ones
        drive(32'h0005_7FFD, 4'hA, 8'd2, 2'd1, 32'h8000_07FC, 4'hA, 1'b0, "R3_R5 dev15");
        // R3: device 16 -> no select line
        drive(32'h0005_8109, 4'hA, 8'd2, 2'd1, 32'h0000_0108, 4'hA, 1'b0, "R3 dev16");
        // R4: bus equals subordinate
        drive(32'h0009_1A05, 4'hA, 8'd2, 2'd2, 32'h0009_1A05, 4'hA, 1'b0, "R4 bus=sub");
        // R4: bus just above secondary
        drive(32'h0006_0001, 4'hB, 8'd2, 2'd2, 32'h0006_0001, 4'hB, 1'b0, "R4 bus=sec+1");
        // R7: above subordinate and below secondary
        drive(32'h000A_0001, 4'hA, 8'd2, 2'd0, 32'h0, 4'h0, 1'b0, "R7 bus=sub+1");
        drive(32'h0004_0001, 4'hB, 8'd2, 2'd0, 32'h0, 4'h0, 1'b0, "R7 bus=sec-1");
        // R6: special cycle pattern
        drive(32'h0005_FF01, 4'hB, 8'd2, 2'd3, 32'h0005_FF01, 4'h1, 1'b1, "R6 special");
        // R6: same pattern as read -> Type 0, dev31 gives no select line
        drive(32'h0005_FF01, 4'hA, 8'd2, 2'd1, 32'h0000_0700, 4'hA, 1'b0, "R6_R3 read not special");
        // R6: nonzero register -> Type 0
        drive(32'h0005_FF05, 4'hB, 8'd2, 2'd1, 32'h0000_0704, 4'hB, 1'b0, "R6 reg1 not special");
        // R6: deeper bus -> Type 1, not special
        drive(32'h0007_FF01, 4'hB, 8'd2, 2'd2, 32'h0007_FF01, 4'hB, 1'b0, "R6_R4 deeper bus");
        // R8: low address pair 00b and non-configuration command
        drive(32'h0005_0000, 4'hB, 8'd2, 2'd0, 32'h0, 4'h0, 1'b0, "R8 kind00");
        drive(32'h0005_0001, 4'h6, 8'd2, 2'd0, 32'h0, 4'h0, 1'b0, "R8 mem cmd");
        // R9: bus equal to primary
        drive(32'h0005_0001, 4'hB, 8'd5, 2'd0, 32'h0, 4'h0, 1'b0, "R9 bus=pri");
        // R2 again after primary restored
        drive(32'h0005_0801, 4'hB, 8'd2, 2'd1, 32'h0002_0000, 4'hB, 1'b0, "R2 dev1");
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d results missing, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule